// File: doc/BRIEF.md
# Ring-Buffer DMA Channel

This block is one channel of a byte-oriented DMA engine that shuttles data between a circular buffer in memory and a byte-wide serial port. Software places the ring with a base address and a power-of-two length, then drives the channel through a small set of word-addressed control registers. In transmit mode software produces into the ring by advancing the write pointer, and the engine consumes from it: it fetches each byte from memory and hands it to the port. In receive mode the roles reverse. The port feeds bytes to the engine, the engine stores them and advances the write pointer, and software consumes by moving the read pointer.

Each pointer is a 16-bit byte offset with a wrap-parity bit above it. The fill level comes from comparing the two wrap bits, so a completely full ring and an empty ring stay distinct. Two derived registers report the fill level and the free space. A sticky interrupt flag fires when the level that matters to software crosses a programmable threshold. The serial side uses two valid/ready streams, one for transmit and one for receive. A producer must hold valid with a stable byte until ready is seen. The engine raises ready on the receive stream only when it can accept a byte. The memory side is a valid/ready request port plus a one-beat read response. The engine holds every request, with its address and data, until the request is accepted.

Top module: `ring_dma_channel`

## Requirements
- R1: After reset, every register reads 0, `irq` is low, and neither `mem_req_valid` nor `tx_valid` is asserted.
- R2: A pointer holds the byte offset in bits [15:0] and a wrap bit in bit 16. When the engine steps a pointer past offset length-1, the offset becomes 0 and bit 16 inverts.
- R3: The fill level (offset 0x3C) is write offset + length - read offset when the wrap bits differ, and write offset - read offset when they match. The free space (offset 0x40) is length minus the fill level.
- R4: In transmit mode (`rx_mode`=0), while the channel is enabled, not stopped and the fill level is nonzero, the engine works one byte at a time. It reads memory at base + read offset, presents the byte on the tx stream, and advances the read pointer when the byte is accepted. It never issues memory writes.
- R5: In receive mode, the engine raises `rx_ready` only while it is enabled, not stopped, idle and the free space is nonzero. It writes each accepted byte to base + write offset and advances the write pointer when the write is accepted.
- R6: `mem_req_valid` and `tx_valid` stay high, with their address, direction and data unchanged, until the matching ready is seen. No byte is lost or duplicated.
- R7: The flag (bit 0 of offset 0x00, driving `irq`) sets while the channel is enabled and its condition holds. In transmit mode the condition is free space >= threshold (offset 0x28) with bit 0 of the enable mask (0x04) set, and any write to 0x00 clears the flag. In receive mode the condition is fill level >= threshold with bit 0 or bit 1 of the mask set, and only a write with bits [1:0]=11 clears the flag; other writes to 0x00 leave it set. The flag stays set after its condition goes away.
- R8: Writing 1 to bit 0 of offset 0x10 blocks new transfers. The enable bit (bit 0 of 0x08) reads 0 once any transfer in flight has finished. While stop is set, writing 1 to the enable bit has no effect.
- R9: Writing 1 to bit 0 of offset 0x0C clears enable, stop, flush, the flag and both pointers.
- R10: In transmit mode, writing 1 to bit 0 of offset 0x14 sets the flush bit. It reads 1 until the fill level is 0 with the engine idle, then clears by itself. In receive mode the write is ignored.
- R11: A software write to the pointer that the engine owns (offset 0x30 in transmit mode, 0x2C in receive mode) is ignored while the channel is enabled. The software-owned pointer can be written at any time.
- R12: Bit 0 of offset 0x54 supplies bit 32 of every memory address. Bits [31:0] are base (0x1C) + pointer offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_mode | input | 1 | 0 = transmit channel, 1 = receive channel; change only while idle |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational from csr_addr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 33 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 8 | Read response byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Port accepts transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine accepts receive byte |
| rx_data | input | 8 | Receive byte |
| irq | output | 1 | Threshold interrupt flag |

## Verification
Because both pointers and the wrap bit can be read back, a wrong internal state shows up as a mismatch in the fill level or free space. That mismatch is visible the cycle after the faulty step. It also shows up in the memory address of the next transfer, which the scoreboard compares against its own model of the pointer. A mover that loses or repeats a byte appears at the next stream or memory handshake as wrong data or an unexpected address. A wrong flag update appears on `irq` within two cycles of the register write or transfer that should have caused it. Stop, flush and wrap are checked around the ring end and with a completely full receive ring.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam logic [7:0] REG_FLAG   = 8'h00;
  localparam logic [7:0] REG_IMASK  = 8'h04;
  localparam logic [7:0] REG_RUN    = 8'h08;
  localparam logic [7:0] REG_WRST   = 8'h0C;
  localparam logic [7:0] REG_HALT   = 8'h10;
  localparam logic [7:0] REG_DRAIN  = 8'h14;
  localparam logic [7:0] REG_BASE   = 8'h1C;
  localparam logic [7:0] REG_SIZE   = 8'h24;
  localparam logic [7:0] REG_LEVEL  = 8'h28;
  localparam logic [7:0] REG_WPTR   = 8'h2C;
  localparam logic [7:0] REG_RPTR   = 8'h30;
  localparam logic [7:0] REG_FILL   = 8'h3C;
  localparam logic [7:0] REG_SPACE  = 8'h40;
  localparam logic [7:0] REG_DBG    = 8'h50;
  localparam logic [7:0] REG_HIADDR = 8'h54;

  typedef enum logic [2:0] {
    MV_IDLE    = 3'd0,
    MV_RD_REQ  = 3'd1,
    MV_RD_WAIT = 3'd2,
    MV_TX_SEND = 3'd3,
    MV_WR_REQ  = 3'd4
  } mv_state_e;
endpackage

// File: rtl/ring_dma_level.sv
module ring_dma_level #(
  parameter int OFS_W = 16
) (
  input  logic [OFS_W:0] wr_ptr,
  input  logic [OFS_W:0] rd_ptr,
  input  logic [OFS_W:0] ring_len,
  output logic [OFS_W:0] fill_cnt,
  output logic [OFS_W:0] space_cnt
);
  logic [OFS_W:0] wofs, rofs;

  always_comb begin
    wofs = {1'b0, wr_ptr[OFS_W-1:0]};
    rofs = {1'b0, rd_ptr[OFS_W-1:0]};
    if (wr_ptr[OFS_W] != rd_ptr[OFS_W]) fill_cnt = wofs + ring_len - rofs;
    else                                fill_cnt = wofs - rofs;
    space_cnt = ring_len - fill_cnt;
  end
endmodule

// File: rtl/ring_dma_mover.sv
module ring_dma_mover
  import ring_dma_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BASE_W = 32,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              run,
  input  logic [OFS_W:0]    fill_cnt,
  input  logic [OFS_W:0]    space_cnt,
  input  logic [OFS_W:0]    rd_ptr,
  input  logic [OFS_W:0]    wr_ptr,
  input  logic [BASE_W-1:0] base_addr,
  input  logic              hi_bit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BYTE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              adv_rd,
  output logic              adv_wr,
  output logic              busy,
  output logic [2:0]        state_code
);
  mv_state_e           state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [BYTE_W-1:0]   byte_q, byte_d;
  logic                tx_start;

  function automatic logic [ADDR_W-1:0] mk_addr(input logic hb, input logic [BASE_W-1:0] b,
                                                input logic [OFS_W:0] p);
    logic [BASE_W-1:0] lo;
    lo = b + BASE_W'(p[OFS_W-1:0]);
    return {hb, lo};
  endfunction

  assign tx_start = run && !rx_mode && (fill_cnt != '0);
  assign rx_ready = (state_q == MV_IDLE) && run && rx_mode && (space_cnt != '0);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    byte_d  = byte_q;
    adv_rd  = 1'b0;
    adv_wr  = 1'b0;
    unique case (state_q)
      MV_IDLE: begin
        if (tx_start) begin
          addr_d  = mk_addr(hi_bit, base_addr, rd_ptr);
          state_d = MV_RD_REQ;
        end else if (rx_valid && rx_ready) begin
          addr_d  = mk_addr(hi_bit, base_addr, wr_ptr);
          byte_d  = rx_data;
          state_d = MV_WR_REQ;
        end
      end
      MV_RD_REQ:  if (mem_req_ready) state_d = MV_RD_WAIT;
      MV_RD_WAIT: if (mem_rsp_valid) begin
        byte_d  = mem_rsp_data;
        state_d = MV_TX_SEND;
      end
      MV_TX_SEND: if (tx_ready) begin
        adv_rd  = 1'b1;
        state_d = MV_IDLE;
      end
      MV_WR_REQ: if (mem_req_ready) begin
        adv_wr  = 1'b1;
        state_d = MV_IDLE;
      end
      default: state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      addr_q  <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      byte_q  <= byte_d;
    end
  end

  assign mem_req_valid = (state_q == MV_RD_REQ) || (state_q == MV_WR_REQ);
  assign mem_req_we    = (state_q == MV_WR_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = byte_q;
  assign tx_valid      = (state_q == MV_TX_SEND);
  assign tx_data       = byte_q;
  assign busy          = (state_q != MV_IDLE);
  assign state_code    = state_q;
endmodule

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BASE_W = 32,
  parameter int CSR_AW = 8,
  parameter int CSR_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [CSR_DW-1:0] csr_wdata,
  output logic [CSR_DW-1:0] csr_rdata,
  input  logic              adv_rd,
  input  logic              adv_wr,
  input  logic              eng_busy,
  input  logic [2:0]        eng_state,
  input  logic [OFS_W:0]    fill_cnt,
  input  logic [OFS_W:0]    space_cnt,
  output logic [OFS_W:0]    wr_ptr,
  output logic [OFS_W:0]    rd_ptr,
  output logic [OFS_W:0]    ring_len,
  output logic [BASE_W-1:0] base_addr,
  output logic              hi_bit,
  output logic              run,
  output logic              irq
);
  localparam int PW = OFS_W + 1;

  logic [1:0]        imask_q;
  logic              en_q, halt_q, drain_q, flag_q, hi_q;
  logic [BASE_W-1:0] base_q;
  logic [OFS_W:0]    len_q, level_q, wptr_q, rptr_q;
  logic              wrst, cond, clr;

  function automatic logic [OFS_W:0] ptr_step(input logic [OFS_W:0] p, input logic [OFS_W:0] len);
    logic [OFS_W:0] n;
    n = {1'b0, p[OFS_W-1:0]} + PW'(1);
    if (n >= len) return {~p[OFS_W], {OFS_W{1'b0}}};
    return {p[OFS_W], n[OFS_W-1:0]};
  endfunction

  function automatic logic hit(input logic we, input logic [CSR_AW-1:0] a, input logic [7:0] r);
    return we && (a == CSR_AW'(r));
  endfunction

  assign wrst = hit(csr_we, csr_addr, REG_WRST) && csr_wdata[0];
  assign cond = en_q && (rx_mode ? ((imask_q != 2'b00) && (fill_cnt >= level_q))
                                 : (imask_q[0] && (space_cnt >= level_q)));
  assign clr  = hit(csr_we, csr_addr, REG_FLAG) && (!rx_mode || (csr_wdata[1:0] == 2'b11));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q <= '0;
      en_q    <= 1'b0;
      halt_q  <= 1'b0;
      drain_q <= 1'b0;
      flag_q  <= 1'b0;
      hi_q    <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      level_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else if (wrst) begin
      en_q    <= 1'b0;
      halt_q  <= 1'b0;
      drain_q <= 1'b0;
      flag_q  <= 1'b0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else begin
      if (hit(csr_we, csr_addr, REG_IMASK))  imask_q <= csr_wdata[1:0];
      if (hit(csr_we, csr_addr, REG_BASE))   base_q  <= csr_wdata[BASE_W-1:0];
      if (hit(csr_we, csr_addr, REG_SIZE))   len_q   <= csr_wdata[OFS_W:0];
      if (hit(csr_we, csr_addr, REG_LEVEL))  level_q <= csr_wdata[OFS_W:0];
      if (hit(csr_we, csr_addr, REG_HIADDR)) hi_q    <= csr_wdata[0];
      if (hit(csr_we, csr_addr, REG_HALT))   halt_q  <= csr_wdata[0];

      if (halt_q && !eng_busy) en_q <= 1'b0;
      else if (hit(csr_we, csr_addr, REG_RUN) && csr_wdata[0] && !halt_q) en_q <= 1'b1;

      if (hit(csr_we, csr_addr, REG_DRAIN) && csr_wdata[0] && !rx_mode) drain_q <= 1'b1;
      else if (drain_q && (fill_cnt == '0) && !eng_busy)               drain_q <= 1'b0;

      if (clr)       flag_q <= 1'b0;
      else if (cond) flag_q <= 1'b1;

      if (hit(csr_we, csr_addr, REG_WPTR) && (!rx_mode || !en_q)) wptr_q <= csr_wdata[OFS_W:0];
      else if (adv_wr) wptr_q <= ptr_step(wptr_q, len_q);

      if (hit(csr_we, csr_addr, REG_RPTR) && (rx_mode || !en_q)) rptr_q <= csr_wdata[OFS_W:0];
      else if (adv_rd) rptr_q <= ptr_step(rptr_q, len_q);
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (csr_addr)
      CSR_AW'(REG_FLAG):   csr_rdata[0]     = flag_q;
      CSR_AW'(REG_IMASK):  csr_rdata[1:0]   = imask_q;
      CSR_AW'(REG_RUN):    csr_rdata[0]     = en_q;
      CSR_AW'(REG_HALT):   csr_rdata[0]     = halt_q;
      CSR_AW'(REG_DRAIN):  csr_rdata[0]     = drain_q;
      CSR_AW'(REG_BASE):   csr_rdata[BASE_W-1:0] = base_q;
      CSR_AW'(REG_SIZE):   csr_rdata[OFS_W:0] = len_q;
      CSR_AW'(REG_LEVEL):  csr_rdata[OFS_W:0] = level_q;
      CSR_AW'(REG_WPTR):   csr_rdata[OFS_W:0] = wptr_q;
      CSR_AW'(REG_RPTR):   csr_rdata[OFS_W:0] = rptr_q;
      CSR_AW'(REG_FILL):   csr_rdata[OFS_W:0] = fill_cnt;
      CSR_AW'(REG_SPACE):  csr_rdata[OFS_W:0] = space_cnt;
      CSR_AW'(REG_DBG):    csr_rdata[3:0]   = {eng_busy, eng_state};
      CSR_AW'(REG_HIADDR): csr_rdata[0]     = hi_q;
      default:             csr_rdata        = '0;
    endcase
  end

  assign wr_ptr    = wptr_q;
  assign rd_ptr    = rptr_q;
  assign ring_len  = len_q;
  assign base_addr = base_q;
  assign hi_bit    = hi_q;
  assign run       = en_q && !halt_q;
  assign irq       = flag_q;
endmodule

// File: rtl/ring_dma_channel.sv
module ring_dma_channel #(
  parameter int OFS_W  = 16,
  parameter int BASE_W = 32,
  parameter int BYTE_W = 8,
  parameter int CSR_AW = 8,
  parameter int CSR_DW = 32,
  localparam int ADDR_W = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [CSR_DW-1:0] csr_wdata,
  output logic [CSR_DW-1:0] csr_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BYTE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              irq
);
  logic [OFS_W:0]    wr_ptr, rd_ptr, ring_len, valid_sz, left_sz;
  logic [BASE_W-1:0] base_addr;
  logic              hi_bit, run, adv_rd, adv_wr, busy;
  logic [2:0]        state_code;

  ring_dma_level #(.OFS_W(OFS_W)) level_i (
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ring_len(ring_len),
    .fill_cnt(valid_sz), .space_cnt(left_sz)
  );

  ring_dma_regs #(.OFS_W(OFS_W), .BASE_W(BASE_W), .CSR_AW(CSR_AW), .CSR_DW(CSR_DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .adv_rd(adv_rd), .adv_wr(adv_wr), .eng_busy(busy), .eng_state(state_code),
    .fill_cnt(valid_sz), .space_cnt(left_sz),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ring_len(ring_len),
    .base_addr(base_addr), .hi_bit(hi_bit), .run(run), .irq(irq)
  );

  ring_dma_mover #(.OFS_W(OFS_W), .BASE_W(BASE_W), .BYTE_W(BYTE_W)) mover_i (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .run(run),
    .fill_cnt(valid_sz), .space_cnt(left_sz), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .base_addr(base_addr), .hi_bit(hi_bit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .adv_rd(adv_rd), .adv_wr(adv_wr), .busy(busy), .state_code(state_code)
  );
endmodule

// File: rtl/ring_dma_channel_chk.sv
module ring_dma_channel_chk #(
  parameter int OFS_W  = 16,
  parameter int BYTE_W = 8,
  parameter int CSR_AW = 8,
  parameter int ADDR_W = 33
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_mode,
  input logic              csr_we,
  input logic [CSR_AW-1:0] csr_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [BYTE_W-1:0] mem_req_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              rx_ready,
  input logic              irq,
  input logic [OFS_W:0]    valid_sz,
  input logic [OFS_W:0]    left_sz,
  input logic [OFS_W:0]    ring_len
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                        && $stable(mem_req_we) && $stable(mem_req_wdata));

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_tx_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode |-> !(mem_req_valid && mem_req_we));

  assert_rx_full_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode && (left_sz == '0) |-> !rx_ready);

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_sz <= ring_len);

  assert_tx_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && (csr_addr == '0) && !rx_mode |=> !irq);
endmodule

bind ring_dma_channel ring_dma_channel_chk #(
  .OFS_W(OFS_W), .BYTE_W(BYTE_W), .CSR_AW(CSR_AW), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .csr_we(csr_we), .csr_addr(csr_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_ready(rx_ready),
  .irq(irq), .valid_sz(valid_sz), .left_sz(left_sz), .ring_len(ring_len)
);

// File: tb/ring_dma_channel_tb_top.sv
module ring_dma_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_mode = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [32:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0]  mem_model [0:255];
  logic [32:0] exp_rd_addr_q [$];
  logic [7:0]  exp_tx_q [$];
  logic [40:0] exp_wr_q [$];

  always #4 clk = ~clk;

  ring_dma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic poll(input logic [7:0] a, input logic [31:0] v, input int lim);
    logic [31:0] d;
    for (int i = 0; i < lim; i++) begin
      rd(a, d);
      if (d == v) break;
    end
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] v);
    logic [31:0] d;
    rd(a, d);
    check(req, d, v);
  endtask

  task automatic push_tx(input int from_ofs, input int n, input logic [31:0] base, input logic hb);
    for (int i = 0; i < n; i++) begin
      int o;
      o = (from_ofs + i) % 16;
      exp_rd_addr_q.push_back({hb, base + 32'(o)});
      exp_tx_q.push_back(mem_model[8'(base + 32'(o))]);
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input int ofs);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1;
    while (!rx_ready) begin
      @(negedge clk);
      #1;
    end
    exp_wr_q.push_back({1'b0, 32'h200 + 32'(ofs), b});
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // memory responder: scoreboard consumer for memory traffic (R4, R5, R12)
  initial begin
    int n = 0;
    logic pend = 1'b0;
    logic [7:0] pdata = '0;
    forever begin
      @(negedge clk);
      n++;
      mem_rsp_valid = pend;
      mem_rsp_data  = pdata;
      pend = 1'b0;
      mem_req_ready = (n % 3) != 1;
      #1;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          if (exp_wr_q.size() == 0) check("R5 unexpected write", {23'd0, mem_req_addr[8:0]}, 32'hx);
          else begin
            logic [40:0] e;
            e = exp_wr_q.pop_front();
            check("R5 write addr R12", mem_req_addr[31:0], e[39:8]);
            check("R12 write addr bit32", {31'd0, mem_req_addr[32]}, {31'd0, e[40]});
            check("R5 write data", {24'd0, mem_req_wdata}, {24'd0, e[7:0]});
          end
        end else begin
          if (exp_rd_addr_q.size() == 0) check("R4 unexpected read", mem_req_addr[31:0], 32'hx);
          else begin
            logic [32:0] ea;
            ea = exp_rd_addr_q.pop_front();
            check("R4 read addr", mem_req_addr[31:0], ea[31:0]);
            check("R12 read addr bit32", {31'd0, mem_req_addr[32]}, {31'd0, ea[32]});
          end
          pend  = 1'b1;
          pdata = mem_model[mem_req_addr[7:0]];
        end
      end
    end
  end

  // tx stream monitor (R4, R6)
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      tx_ready = (n % 4) != 2;
      #1;
      if (tx_valid && tx_ready) begin
        if (exp_tx_q.size() == 0) check("R6 unexpected tx byte", {24'd0, tx_data}, 32'hx);
        else check("R4 tx byte", {24'd0, tx_data}, {24'd0, exp_tx_q.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL R1 watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 256; i++) mem_model[i] = 8'(i * 13 + 5);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg("R1 enable", 8'h08, 32'd0);
    expect_reg("R1 wptr", 8'h2C, 32'd0);
    expect_reg("R1 space", 8'h40, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 req/tx idle", {30'd0, mem_req_valid, tx_valid}, 32'd0);

    // transmit configuration
    wr(8'h1C, 32'h100);
    wr(8'h24, 32'd16);
    wr(8'h54, 32'd1);
    wr(8'h28, 32'd17);
    wr(8'h04, 32'd1);
    wr(8'h2C, 32'd5);
    push_tx(0, 5, 32'h100, 1'b1);
    expect_reg("R3 fill", 8'h3C, 32'd5);
    expect_reg("R3 space", 8'h40, 32'd11);
    wr(8'h08, 32'd1);
    repeat (2) @(negedge clk);
    check("R7 tx below threshold", {31'd0, irq}, 32'd0);
    poll(8'h3C, 32'd0, 500);
    expect_reg("R4 drained", 8'h3C, 32'd0);
    expect_reg("R4 rptr", 8'h30, 32'd5);
    wr(8'h30, 32'd3);
    expect_reg("R11 engine-owned rptr", 8'h30, 32'd5);

    // stop
    wr(8'h10, 32'd1);
    poll(8'h08, 32'd0, 50);
    expect_reg("R8 enable after stop", 8'h08, 32'd0);
    wr(8'h08, 32'd1);
    expect_reg("R8 enable blocked", 8'h08, 32'd0);

    // wrapped producer pointer
    wr(8'h2C, 32'h1_0002);
    push_tx(5, 13, 32'h100, 1'b1);
    expect_reg("R3 wrapped fill", 8'h3C, 32'd13);
    expect_reg("R3 wrapped space", 8'h40, 32'd3);
    wr(8'h14, 32'd1);
    expect_reg("R10 flush pending", 8'h14, 32'd1);
    wr(8'h28, 32'd16);
    wr(8'h10, 32'd0);
    wr(8'h08, 32'd1);
    poll(8'h14, 32'd0, 2000);
    expect_reg("R10 flush done", 8'h14, 32'd0);
    expect_reg("R2 rptr wrapped", 8'h30, 32'h1_0002);
    expect_reg("R3 empty", 8'h3C, 32'd0);
    repeat (2) @(negedge clk);
    check("R7 tx threshold reached", {31'd0, irq}, 32'd1);
    wr(8'h28, 32'd17);
    wr(8'h00, 32'd0);
    @(negedge clk);
    check("R7 tx flag cleared", {31'd0, irq}, 32'd0);
    check("R4 tx queue empty", exp_tx_q.size(), 32'd0);

    // warm reset
    wr(8'h0C, 32'd1);
    expect_reg("R9 enable", 8'h08, 32'd0);
    expect_reg("R9 wptr", 8'h2C, 32'd0);
    expect_reg("R9 rptr", 8'h30, 32'd0);
    check("R9 irq", {31'd0, irq}, 32'd0);

    // receive
    @(negedge clk);
    rx_mode = 1'b1;
    wr(8'h1C, 32'h200);
    wr(8'h24, 32'd8);
    wr(8'h54, 32'd0);
    wr(8'h28, 32'd3);
    wr(8'h04, 32'd2);
    wr(8'h08, 32'd1);
    for (int i = 0; i < 3; i++) send_rx(8'hA0 + 8'(i), i);
    poll(8'h3C, 32'd3, 100);
    expect_reg("R5 wptr", 8'h2C, 32'd3);
    repeat (2) @(negedge clk);
    check("R7 rx threshold", {31'd0, irq}, 32'd1);
    wr(8'h30, 32'd3);
    expect_reg("R11 software rptr", 8'h30, 32'd3);
    check("R7 sticky flag", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'd1);
    @(negedge clk);
    check("R7 partial clear ignored", {31'd0, irq}, 32'd1);
    wr(8'h00, 32'd3);
    @(negedge clk);
    check("R7 rx clear", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 8; i++) send_rx(8'h50 + 8'(i), (3 + i) % 8);
    poll(8'h40, 32'd0, 100);
    expect_reg("R2 wptr wrapped", 8'h2C, 32'h1_0003);
    expect_reg("R3 full fill", 8'h3C, 32'd8);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hEE;
    repeat (4) @(negedge clk);
    #1 check("R5 full back-pressure", {31'd0, rx_ready}, 32'd0);
    @(negedge clk);
    rx_valid = 1'b0;
    wr(8'h14, 32'd1);
    expect_reg("R10 rx flush ignored", 8'h14, 32'd0);
    wr(8'h10, 32'd1);
    poll(8'h08, 32'd0, 50);
    expect_reg("R8 rx stop", 8'h08, 32'd0);
    repeat (4) @(negedge clk);
    check("R6 write queue empty", exp_wr_q.size(), 32'd0);
    check("R6 read queue empty", exp_rd_addr_q.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule